// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR graphics SDRAM. It takes the memory from power-on to a ready state. It holds the clock enable low through a stable-clock wait, then raises it behind a no-operation cycle. It then issues a fixed series of commands on decoded command strobes, with the bank and address bits each command needs. The series is:

1. a precharge of every bank;
2. an extended mode write that switches the DLL on;
3. a mode write that resets the DLL;
4. a second precharge of every bank;
5. a run of auto refreshes;
6. a last mode write with the DLL reset bit cleared.

Each gap between commands is a parameter in clock cycles. The block raises its done output only after the final mode write has settled and after the DLL lock window, counted from the DLL reset, has run out.

The burst length code, burst type and output drive strength are inputs. The block samples them once, when the power-up wait ends, and writes them into the two mode words. If a code is illegal, all three settings fall back to a safe default. After an operating-frequency change, a restart pulse sent while the block is done repeats the series from the DLL reset step. The clock enable stays high during that repeat.

Top module: `ddrinit_seq`

## Requirements
- R1: After reset release, `cke` is low and the command is NOP for exactly STABLE_CLKS cycles. In the next cycle `cke` rises with a NOP. After that `cke` never falls.
- R2: The command code `{cs_n,ras_n,cas_n,we_n}` is 0111 for NOP, 0010 for precharge (with address bit 10 high, selecting all banks), 0001 for auto refresh and 0000 for a mode write. The command order after `cke` rises is: precharge, extended mode write, DLL-reset mode write, precharge, REFRESH_COUNT auto refreshes, final mode write. Every other cycle carries NOP.
- R3: The first precharge comes one cycle after `cke` rises. The next command follows a precharge by exactly TRP_CLKS cycles, a mode write by exactly TMRD_CLKS cycles, and an auto refresh by exactly TRFC_CLKS cycles.
- R4: The extended mode write drives `ba` = 01 and address bit 0 = 0 (DLL enabled). It puts drive code bit 0 on address bit 1 and drive code bit 1 on address bit 6, and all other address bits are 0. Drive code 00 is full, 01 weak, 10 matched.
- R5: Both normal mode writes drive `ba` = 00. Address bits 2:0 carry the burst length code (001=2, 010=4, 011=8), bit 3 the burst type (0 sequential, 1 interleaved), and bits 6:4 the latency code 011. Bit 7 is 0. Bit 8 is 1 on the DLL-reset write and 0 on the final write, and bits 12:9 are 0.
- R6: The configuration inputs are sampled in the last cycle of the power-up wait. Changing them later has no effect on the words written.
- R7: A burst length code other than 001/010/011, or drive code 11, makes the block write burst code 010, sequential type and drive code 00.
- R8: `init_done` rises one cycle after the later of two points: TMRD_CLKS cycles past the final mode write, and LOCK_CLKS cycles past the DLL-reset mode write. It then stays high until a restart.
- R9: A `restart` pulse while `init_done` is high gives the DLL-reset mode write in the next cycle, with `init_done` low. Then come precharge, the refreshes and the final mode write at the R3 spacings, and `init_done` rises again under the R8 rule. No extended mode write is sent, and `cke` stays high.
- R10: `restart` pulsed before `init_done` is high has no effect on the command series or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_burst_len | input | 3 | Burst length code |
| cfg_burst_type | input | 1 | Burst type, 1 = interleaved |
| cfg_drive | input | 2 | Output drive strength code |
| restart | input | 1 | Repeat the series from the DLL reset (accepted only when done) |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | ADDR_W | Address bits for mode words and precharge-all |
| init_done | output | 1 | Memory ready for normal traffic |

## Verification
The case hardest to reach from the ports is one that follows a frequency change: the DLL lock window, not the command spacing, decides when `init_done` rises. The bench exposes it by comparing the done cycle after a restart against the lock-window formula, since the restart path has no extended mode write before it.

The fallback path needs illegal burst and drive codes. Seeded random configurations are mixed with directed illegal codes to reach it. The bench changes the configuration inputs after the sampling point, and fires restart pulses in the middle of the series, to show that neither leaks into the command stream.

// File: rtl/ddrinit_pkg.sv
package ddrinit_pkg;

  typedef enum logic [3:0] {
    ST_POWER,
    ST_CKE,
    ST_PREA1,
    ST_EMRS,
    ST_MRS_RST,
    ST_PREA2,
    ST_AREF,
    ST_MRS_RUN,
    ST_GAP,
    ST_LOCK,
    ST_DONE
  } step_t;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MODE      = 4'b0000,
    CMD_REFRESH   = 4'b0001,
    CMD_PRECHARGE = 4'b0010,
    CMD_NOP       = 4'b0111
  } cmd_t;

  localparam logic [2:0] LATENCY_CODE  = 3'b011;
  localparam logic [2:0] BL_SAFE       = 3'b010;
  localparam logic [1:0] DRIVE_SAFE    = 2'b00;
  localparam int         DLL_RST_BIT   = 8;
  localparam int         ALL_BANK_BIT  = 10;
  localparam logic [1:0] BA_EXT        = 2'b01;

endpackage

// File: rtl/ddrinit_timer.sv
module ddrinit_timer #(
  parameter int           W         = 8,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] count_q;
  logic [W-1:0] count_d;
  logic         count_en;

  always_comb begin
    count_en = load || (count_q != '0);
    count_d  = load ? load_val : count_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= RESET_VAL;
    else if (count_en) count_q <= count_d;
  end

  assign expired = (count_q == '0);

endmodule

// File: rtl/ddrinit_cfg.sv
module ddrinit_cfg
  import ddrinit_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_burst_type,
  input  logic [1:0]        cfg_drive,
  output logic [ADDR_W-1:0] mode_word,
  output logic [ADDR_W-1:0] ext_word
);

  logic [2:0] bl_q;
  logic       bt_q;
  logic [1:0] drv_q;
  logic       legal;

  always_comb begin
    legal = (cfg_burst_len inside {3'b001, 3'b010, 3'b011}) && (cfg_drive != 2'b11);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bl_q  <= BL_SAFE;
      bt_q  <= 1'b0;
      drv_q <= DRIVE_SAFE;
    end else if (capture) begin
      bl_q  <= legal ? cfg_burst_len  : BL_SAFE;
      bt_q  <= legal ? cfg_burst_type : 1'b0;
      drv_q <= legal ? cfg_drive      : DRIVE_SAFE;
    end
  end

  always_comb begin
    mode_word      = '0;
    mode_word[2:0] = bl_q;
    mode_word[3]   = bt_q;
    mode_word[6:4] = LATENCY_CODE;
    ext_word       = '0;
    ext_word[1]    = drv_q[0];
    ext_word[6]    = drv_q[1];
  end

endmodule

// File: rtl/ddrinit_seq.sv
module ddrinit_seq
  import ddrinit_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int STABLE_CLKS   = 20000,
  parameter int TRP_CLKS      = 4,
  parameter int TMRD_CLKS     = 2,
  parameter int TRFC_CLKS     = 14,
  parameter int LOCK_CLKS     = 200,
  parameter int REFRESH_COUNT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_burst_len,
  input  logic              cfg_burst_type,
  input  logic [1:0]        cfg_drive,
  input  logic              restart,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  localparam int GAP_A   = (TRP_CLKS > TMRD_CLKS) ? TRP_CLKS : TMRD_CLKS;
  localparam int GAP_B   = (GAP_A > TRFC_CLKS) ? GAP_A : TRFC_CLKS;
  localparam int GAP_MAX = (GAP_B > STABLE_CLKS) ? GAP_B : STABLE_CLKS;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);
  localparam int LOCK_W  = $clog2(LOCK_CLKS + 1);
  localparam int REF_W   = $clog2(REFRESH_COUNT + 1);

  localparam logic [GAP_W-1:0]  TRP_LD  = GAP_W'(TRP_CLKS - 2);
  localparam logic [GAP_W-1:0]  TMRD_LD = GAP_W'(TMRD_CLKS - 2);
  localparam logic [GAP_W-1:0]  TRFC_LD = GAP_W'(TRFC_CLKS - 2);
  localparam logic [LOCK_W-1:0] LOCK_LD = LOCK_W'(LOCK_CLKS - 1);
  localparam logic [REF_W-1:0]  REF_LAST = REF_W'(REFRESH_COUNT - 1);

  step_t             state_q, state_d;
  step_t             ret_q, ret_d;
  logic [REF_W-1:0]  ref_q, ref_d;
  logic              gap_load, gap_exp;
  logic [GAP_W-1:0]  gap_val;
  logic              lock_load, lock_exp;
  logic              capture;
  logic [ADDR_W-1:0] mode_word, ext_word;
  cmd_t              cmd;

  ddrinit_timer #(.W(GAP_W), .RESET_VAL(GAP_W'(STABLE_CLKS - 1))) u_gap (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .load_val(gap_val), .expired(gap_exp)
  );

  ddrinit_timer #(.W(LOCK_W), .RESET_VAL('0)) u_lock (
    .clk(clk), .rst_n(rst_n), .load(lock_load), .load_val(LOCK_LD), .expired(lock_exp)
  );

  ddrinit_cfg #(.ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .capture(capture),
    .cfg_burst_len(cfg_burst_len), .cfg_burst_type(cfg_burst_type), .cfg_drive(cfg_drive),
    .mode_word(mode_word), .ext_word(ext_word)
  );

  // next-state process
  always_comb begin
    state_d   = state_q;
    ret_d     = ret_q;
    ref_d     = ref_q;
    gap_load  = 1'b0;
    gap_val   = '0;
    lock_load = 1'b0;
    capture   = 1'b0;
    case (state_q)
      ST_POWER: if (gap_exp) begin
        capture = 1'b1;
        state_d = ST_CKE;
      end
      ST_CKE:   state_d = ST_PREA1;
      ST_PREA1: begin
        gap_load = 1'b1; gap_val = TRP_LD;  ret_d = ST_EMRS;    state_d = ST_GAP;
      end
      ST_EMRS: begin
        gap_load = 1'b1; gap_val = TMRD_LD; ret_d = ST_MRS_RST; state_d = ST_GAP;
      end
      ST_MRS_RST: begin
        lock_load = 1'b1;
        gap_load  = 1'b1; gap_val = TMRD_LD; ret_d = ST_PREA2;  state_d = ST_GAP;
      end
      ST_PREA2: begin
        ref_d    = '0;
        gap_load = 1'b1; gap_val = TRP_LD;  ret_d = ST_AREF;    state_d = ST_GAP;
      end
      ST_AREF: begin
        ref_d    = ref_q + 1'b1;
        gap_load = 1'b1; gap_val = TRFC_LD;
        ret_d    = (ref_q == REF_LAST) ? ST_MRS_RUN : ST_AREF;
        state_d  = ST_GAP;
      end
      ST_MRS_RUN: begin
        gap_load = 1'b1; gap_val = TMRD_LD; ret_d = ST_LOCK;    state_d = ST_GAP;
      end
      ST_GAP:   if (gap_exp)  state_d = ret_q;
      ST_LOCK:  if (lock_exp) state_d = ST_DONE;
      ST_DONE:  if (restart)  state_d = ST_MRS_RST;
      default:  state_d = ST_POWER;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_POWER;
      ret_q   <= ST_POWER;
      ref_q   <= '0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      ref_q   <= ref_d;
    end
  end

  // output decode
  always_comb begin
    cmd  = CMD_NOP;
    ba   = '0;
    addr = '0;
    case (state_q)
      ST_PREA1, ST_PREA2: begin
        cmd = CMD_PRECHARGE;
        addr[ALL_BANK_BIT] = 1'b1;
      end
      ST_EMRS: begin
        cmd  = CMD_MODE;
        ba   = BA_EXT;
        addr = ext_word;
      end
      ST_MRS_RST: begin
        cmd  = CMD_MODE;
        addr = mode_word;
        addr[DLL_RST_BIT] = 1'b1;
      end
      ST_MRS_RUN: begin
        cmd  = CMD_MODE;
        addr = mode_word;
      end
      ST_AREF: cmd = CMD_REFRESH;
      default: cmd = CMD_NOP;
    endcase
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign cke       = (state_q != ST_POWER);
  assign init_done = (state_q == ST_DONE);

  // R1
  cke_low_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> ({cs_n, ras_n, cas_n, we_n} == CMD_NOP));

  // R1
  cke_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);

  // R3
  mode_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({cs_n, ras_n, cas_n, we_n} == CMD_MODE) |=> ({cs_n, ras_n, cas_n, we_n} == CMD_NOP));

  // R5
  latency_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (({cs_n, ras_n, cas_n, we_n} == CMD_MODE) && (ba == 2'b00)) |-> (addr[6:4] == 3'b011 && !addr[7]));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && !restart) |=> init_done);

  // R9
  restart_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && restart) |=> (!init_done && ({cs_n, ras_n, cas_n, we_n} == CMD_MODE) && addr[DLL_RST_BIT]));

endmodule

// File: tb/ddrinit_seq_test.sv
module ddrinit_seq_test;

  localparam int S    = 300;
  localparam int TRP  = 4;
  localparam int TMRD = 2;
  localparam int TRFC = 14;
  localparam int LOCK = 200;
  localparam int NREF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_bl = 3'b010;
  logic        cfg_bt = 1'b0;
  logic [1:0]  cfg_drv = 2'b00;
  logic        restart = 1'b0;
  logic        cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [1:0]  ba;
  logic [12:0] addr;

  ddrinit_seq #(.ADDR_W(13), .STABLE_CLKS(S), .TRP_CLKS(TRP), .TMRD_CLKS(TMRD),
                .TRFC_CLKS(TRFC), .LOCK_CLKS(LOCK), .REFRESH_COUNT(NREF)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_burst_len(cfg_bl), .cfg_burst_type(cfg_bt),
    .cfg_drive(cfg_drv), .restart(restart), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done)
  );

  always #5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // command log sampled away from the active edge
  int          lg_n;
  int          lg_cyc  [0:15];
  logic [3:0]  lg_cmd  [0:15];
  logic [12:0] lg_addr [0:15];
  logic [1:0]  lg_ba   [0:15];
  int          first_cke;
  int          done_cyc;
  bit          cke_drop;
  logic        prev_cke;

  always @(negedge clk) begin
    if (rst_n) begin
      if ({cs_n, ras_n, cas_n, we_n} != 4'b0111 && lg_n < 16) begin
        lg_cyc[lg_n]  = cyc;
        lg_cmd[lg_n]  = {cs_n, ras_n, cas_n, we_n};
        lg_addr[lg_n] = addr;
        lg_ba[lg_n]   = ba;
        lg_n++;
      end
      if (cke && first_cke < 0) first_cke = cyc;
      if (prev_cke && !cke) cke_drop = 1'b1;
      if (init_done && done_cyc < 0) done_cyc = cyc;
      prev_cke = cke;
    end
  end

  task automatic clear_log();
    lg_n = 0; first_cke = -1; done_cyc = -1; cke_drop = 1'b0;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic bit legal_cfg(input logic [2:0] bl, input logic [1:0] drv);
    return (bl == 3'b001 || bl == 3'b010 || bl == 3'b011) && drv != 2'b11;
  endfunction

  function automatic logic [12:0] exp_mode(input logic [2:0] bl, input logic bt,
                                            input logic [1:0] drv, input logic dllrst);
    logic [12:0] w;
    bit ok;
    ok = legal_cfg(bl, drv);
    w = '0;
    w[2:0] = ok ? bl : 3'b010;
    w[3]   = ok ? bt : 1'b0;
    w[6:4] = 3'b011;
    w[8]   = dllrst;
    return w;
  endfunction

  function automatic logic [12:0] exp_ext(input logic [2:0] bl, input logic [1:0] drv);
    logic [12:0] w;
    logic [1:0] d;
    d = legal_cfg(bl, drv) ? drv : 2'b00;
    w = '0;
    w[1] = d[0];
    w[6] = d[1];
    return w;
  endfunction

  task automatic chk_entry(input int i, input logic [3:0] c, input int t,
                           input logic [12:0] a, input logic [1:0] b, input string req);
    chk(lg_cmd[i] == c, req, int'(lg_cmd[i]), int'(c));
    chk(lg_cyc[i] == t, req, lg_cyc[i], t);
    chk(lg_addr[i] == a && lg_ba[i] == b, req, int'({lg_ba[i], lg_addr[i]}), int'({b, a}));
  endtask

  // checks the tail from the DLL-reset mode write at cycle m, starting at log index k
  task automatic chk_tail(input int k, input int m, input logic [2:0] bl, input logic bt,
                          input logic [1:0] drv);
    logic [12:0] pre;
    int t;
    pre = '0; pre[10] = 1'b1;
    chk_entry(k, 4'b0000, m, exp_mode(bl, bt, drv, 1'b1), 2'b00, "R5");
    t = m + TMRD;
    chk_entry(k + 1, 4'b0010, t, pre, 2'b00, "R3");
    t = t + TRP;
    for (int i = 0; i < NREF; i++) begin
      chk_entry(k + 2 + i, 4'b0001, t, 13'd0, 2'b00, "R2");
      t = t + TRFC;
    end
    chk_entry(k + 2 + NREF, 4'b0000, t, exp_mode(bl, bt, drv, 1'b0), 2'b00, "R5");
    chk(done_cyc == ((t + TMRD > m + LOCK) ? t + TMRD : m + LOCK) + 1, "R8",
        done_cyc, ((t + TMRD > m + LOCK) ? t + TMRD : m + LOCK) + 1);
  endtask

  task automatic run_case(input logic [2:0] bl, input logic bt, input logic [1:0] drv,
                          input bit early_restart);
    logic [12:0] pre;
    int r;
    int guard;
    pre = '0; pre[10] = 1'b1;
    rst_n = 1'b0; restart = 1'b0;
    cfg_bl = bl; cfg_bt = bt; cfg_drv = drv;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cke == 1'b0 && {cs_n, ras_n, cas_n, we_n} == 4'b0111 && !init_done, "R1",
        int'({cke, cs_n, ras_n, cas_n, we_n, init_done}), 6'b001110);
    @(negedge clk); #1;
    clear_log();
    prev_cke = 1'b0;
    rst_n = 1'b1;
    // R6: change configuration after the sampling point
    while (cyc < S + 2) @(negedge clk);
    #1;
    cfg_bl = bl ^ 3'b101; cfg_bt = ~bt; cfg_drv = ~drv;
    if (early_restart) begin
      // R10: pulse before done
      while (cyc < S + 20) @(negedge clk);
      #1; restart = 1'b1;
      repeat (3) @(negedge clk);
      #1; restart = 1'b0;
    end
    guard = 0;
    while (done_cyc < 0 && guard < 3000) begin @(negedge clk); guard++; end
    chk(first_cke == S, "R1", first_cke, S);
    chk(lg_n == 5 + NREF, early_restart ? "R10" : "R2", lg_n, 5 + NREF);
    if (lg_n == 5 + NREF) begin
      chk_entry(0, 4'b0010, S + 1, pre, 2'b00, "R3");
      chk_entry(1, 4'b0000, S + 1 + TRP, exp_ext(bl, drv), 2'b01,
                legal_cfg(bl, drv) ? "R4" : "R7");
      chk_tail(2, S + 1 + TRP + TMRD, bl, bt, drv);
    end
    // R9: restart after done
    repeat (4) @(negedge clk);
    #1;
    clear_log();
    restart = 1'b1; r = cyc;
    @(negedge clk); #1;
    restart = 1'b0;
    chk(init_done == 1'b0, "R9", int'(init_done), 0);
    guard = 0;
    while (done_cyc < 0 && guard < 3000) begin @(negedge clk); guard++; end
    chk(lg_n == 3 + NREF, "R9", lg_n, 3 + NREF);
    if (lg_n == 3 + NREF) chk_tail(0, r + 1, bl, bt, drv);
    chk(!cke_drop && cke, "R9", int'(cke_drop), 0);
  endtask

  initial begin
    int seed_val;
    seed_val = $urandom(32'h5eed);
    run_case(3'b010, 1'b0, 2'b00, 1'b0);
    run_case(3'b011, 1'b1, 2'b10, 1'b1);
    run_case(3'b001, 1'b0, 2'b01, 1'b0);
    run_case(3'b000, 1'b1, 2'b01, 1'b0);   // R7 illegal burst
    run_case(3'b010, 1'b1, 2'b11, 1'b1);   // R7 illegal drive
    run_case(3'b111, 1'b1, 2'b10, 1'b0);   // R7 illegal burst
    for (int i = 0; i < 6; i++) begin
      run_case(3'($urandom), 1'($urandom), 2'($urandom), 1'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule